// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This unit holds a small file of shared counter registers ("bases") and serves atomic fetch-and-add style prefix-sum operations on them from several requesters at once. Each requester presents a valid flag, the index of the base it targets and a 32-bit increment. It gets back the value the base held before its own increment was applied. The targeted base moves forward by that increment.

When several requesters name the same base in one cycle, the unit folds them into one multi-operand update. Each one receives a distinct partial sum, and the base advances once by the total. Among same-base requesters in a cycle, the lower requester number is served first. Requesters that target different bases do not interact. A separate load port sets the initial value of a base. Responses appear exactly one cycle after the request, and a request in the following cycle already sees the updated base. This makes the unit suitable for handing out unique slot numbers to many threads that compact data into a shared array.

Top module: `psu_top`

## Requirements
- R1: After reset, every base reads 0 and no response valid bit is set.
- R2: When `ld_en` is high, base `ld_idx` takes `ld_val` at the clock edge, and a request in the next cycle sees that value.
- R3: A lone valid request to a base returns the base value before the request, and the base grows by the request's increment.
- R4: `rsp_vld[k]` equals `req_vld[k]` from the previous cycle. `rsp_val` lane k is zero whenever `rsp_vld[k]` is low.
- R5: Among valid requests to the same base in one cycle, requester k receives the base plus the sum of increments of valid same-base requesters with a lower number than k.
- R6: After a cycle of same-base requests, the base equals its old value plus the sum of all their increments.
- R7: Requests to different bases in the same cycle produce results as if each had been issued alone.
- R8: When all requesters target one base with increment 1, they receive consecutive distinct values, from the old base up to the old base plus N_REQ minus 1.
- R9: A request issued in the cycle right after an update sees the fully updated base.
- R10: Base values and results wrap modulo 2^32, with no flag.
- R11: If a load and requests hit the same base in one cycle, the requests see the pre-load value and the base takes `ld_val`. The increments of that cycle are dropped for that base.
- R12: Index and increment of a requester whose valid bit is low change no base and no other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N_REQ | Request valid, one bit per requester |
| req_idx | input | N_REQ*IW | Base index per requester; lane k at bits [k*IW +: IW] |
| req_inc | input | N_REQ*32 | Increment per requester; lane k at bits [k*32 +: 32] |
| ld_en | input | 1 | Load strobe for the base file |
| ld_idx | input | IW | Base index to load |
| ld_val | input | 32 | Value to load |
| rsp_vld | output | N_REQ | Response valid, one cycle after the request |
| rsp_val | output | N_REQ*32 | Pre-increment prefix per requester; lane k at bits [k*32 +: 32] |

## Verification
Several properties are checked on every clock edge: the one-cycle valid latency and zeroed idle lanes, the chaining rule that adjacent same-base requesters differ by exactly the lower one's increment, and the back-to-back rule for a single requester. Whether the absolute returned values match the bases is only shown by the bench. It does this with a sweep over every index pattern and valid mask of a four-requester, four-base configuration against an arithmetic model. The bench also covers the load-versus-increment collision, wraparound, and the proof that masked lanes leave bases untouched, which it reads back through zero-increment requests.

// File: rtl/psu_pkg.sv
package psu_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/psu_prefix_net.sv
// Combinational combining network: per-requester exclusive prefix among
// same-base requesters (ascending requester order) and per-base totals.
module psu_prefix_net
    import psu_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int N_BASE = 4,
    parameter int IW     = 2
) (
    input  logic [N_REQ-1:0] vld,
    input  logic [IW-1:0]    idx    [N_REQ],
    input  word_t            inc    [N_REQ],
    output word_t            offset [N_REQ],
    output word_t            total  [N_BASE]
);
    for (genvar k = 0; k < N_REQ; k++) begin : g_off
        word_t acc;
        always_comb begin
            acc = '0;
            for (int j = 0; j < k; j++) begin
                if (vld[j] && (idx[j] == idx[k])) begin
                    acc = acc + inc[j];
                end
            end
        end
        assign offset[k] = acc;
    end

    for (genvar b = 0; b < N_BASE; b++) begin : g_tot
        word_t sum;
        always_comb begin
            sum = '0;
            for (int j = 0; j < N_REQ; j++) begin
                if (vld[j] && (idx[j] == IW'(b))) begin
                    sum = sum + inc[j];
                end
            end
        end
        assign total[b] = sum;
    end
endmodule

// File: rtl/psu_base_file.sv
// Base register file: each base advances by its combined total or is loaded.
module psu_base_file
    import psu_pkg::*;
#(
    parameter int N_BASE = 4,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  word_t         total  [N_BASE],
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  word_t         ld_val,
    output word_t         base   [N_BASE]
);
    typedef struct packed {
        logic [N_BASE-1:0][WORD_W-1:0] base;
    } bf_state_t;

    bf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < N_BASE; b++) begin
            if (ld_en && (ld_idx == IW'(b))) begin
                st_d.base[b] = ld_val;
            end else begin
                st_d.base[b] = st_q.base[b] + total[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < N_BASE; b++) begin : g_out
        assign base[b] = st_q.base[b];
    end
endmodule

// File: rtl/psu_top.sv
module psu_top
    import psu_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int N_BASE = 4,
    parameter int IW     = (N_BASE > 1) ? $clog2(N_BASE) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req_vld,
    input  logic [N_REQ*IW-1:0]     req_idx,
    input  logic [N_REQ*WORD_W-1:0] req_inc,
    input  logic                    ld_en,
    input  logic [IW-1:0]           ld_idx,
    input  logic [WORD_W-1:0]       ld_val,
    output logic [N_REQ-1:0]        rsp_vld,
    output logic [N_REQ*WORD_W-1:0] rsp_val
);
    typedef struct packed {
        logic [N_REQ-1:0]              vld;
        logic [N_REQ-1:0][WORD_W-1:0]  val;
    } rsp_state_t;

    logic [IW-1:0] idx_a    [N_REQ];
    word_t         inc_a    [N_REQ];
    word_t         offset_a [N_REQ];
    word_t         total_a  [N_BASE];
    word_t         base_a   [N_BASE];

    for (genvar k = 0; k < N_REQ; k++) begin : g_lane
        assign idx_a[k] = req_idx[k*IW +: IW];
        assign inc_a[k] = req_inc[k*WORD_W +: WORD_W];
    end

    psu_prefix_net #(
        .N_REQ (N_REQ),
        .N_BASE(N_BASE),
        .IW    (IW)
    ) u_net (
        .vld   (req_vld),
        .idx   (idx_a),
        .inc   (inc_a),
        .offset(offset_a),
        .total (total_a)
    );

    psu_base_file #(
        .N_BASE(N_BASE),
        .IW    (IW)
    ) u_bases (
        .clk   (clk),
        .rst_n (rst_n),
        .total (total_a),
        .ld_en (ld_en),
        .ld_idx(ld_idx),
        .ld_val(ld_val),
        .base  (base_a)
    );

    rsp_state_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_vld;
        for (int k = 0; k < N_REQ; k++) begin
            if (req_vld[k]) begin
                rsp_d.val[k] = base_a[idx_a[k]] + offset_a[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld = rsp_q.vld;
    assign rsp_val = rsp_q.val;
endmodule

// File: rtl/psu_top_chk.sv
module psu_top_chk
    import psu_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int N_BASE = 4,
    parameter int IW     = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_REQ-1:0]        req_vld,
    input logic [N_REQ*IW-1:0]     req_idx,
    input logic [N_REQ*WORD_W-1:0] req_inc,
    input logic                    ld_en,
    input logic [N_REQ-1:0]        rsp_vld,
    input logic [N_REQ*WORD_W-1:0] rsp_val
);
    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == $past(req_vld));

    for (genvar k = 0; k < N_REQ; k++) begin : g_idle
        // R4
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_vld[k] |-> (rsp_val[k*WORD_W +: WORD_W] == '0));
    end

    for (genvar k = 1; k < N_REQ; k++) begin : g_chain
        // R5
        rsp_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(req_vld[k]) && $past(req_vld[k-1]) &&
             ($past(req_idx[k*IW +: IW]) == $past(req_idx[(k-1)*IW +: IW])))
            |-> (rsp_val[k*WORD_W +: WORD_W] ==
                 rsp_val[(k-1)*WORD_W +: WORD_W] + $past(req_inc[(k-1)*WORD_W +: WORD_W])));
    end

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld == N_REQ'(1) && $past(req_vld, 2) == N_REQ'(1) && !$past(ld_en, 2) &&
         ($past(req_idx[IW-1:0], 2) == $past(req_idx[IW-1:0])))
        |-> (rsp_val[WORD_W-1:0] == $past(rsp_val[WORD_W-1:0]) + $past(req_inc[WORD_W-1:0], 2)));
endmodule

bind psu_top psu_top_chk #(
    .N_REQ (N_REQ),
    .N_BASE(N_BASE),
    .IW    (IW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_vld(req_vld),
    .req_idx(req_idx),
    .req_inc(req_inc),
    .ld_en  (ld_en),
    .rsp_vld(rsp_vld),
    .rsp_val(rsp_val)
);

// File: tb/psu_top_test.sv
module psu_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int NB = 4;
    localparam int IW = 2;
    localparam int W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_vld = '0;
    logic [N*IW-1:0]   req_idx = '0;
    logic [N*W-1:0]    req_inc = '0;
    logic              ld_en = 1'b0;
    logic [IW-1:0]     ld_idx = '0;
    logic [W-1:0]      ld_val = '0;
    logic [N-1:0]      rsp_vld;
    logic [N*W-1:0]    rsp_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [W-1:0] model [NB];
    logic [W-1:0] got   [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    psu_top #(.N_REQ(N), .N_BASE(NB)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_idx(req_idx), .req_inc(req_inc),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .rsp_vld(rsp_vld), .rsp_val(rsp_val)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives, waits for the result edge, checks.
    task automatic step(input logic [N-1:0] v, input logic [N*IW-1:0] ix, input logic [N*W-1:0] in,
                        input logic le, input logic [IW-1:0] li, input logic [W-1:0] lv, input string tag);
        logic [W-1:0] exp [N];
        logic [W-1:0] tot [NB];
        for (int b = 0; b < NB; b++) tot[b] = '0;
        for (int k = 0; k < N; k++) begin
            exp[k] = '0;
            if (v[k]) begin
                exp[k] = model[ix[k*IW +: IW]];
                for (int j = 0; j < k; j++)
                    if (v[j] && ix[j*IW +: IW] == ix[k*IW +: IW]) exp[k] = exp[k] + in[j*W +: W];
                tot[ix[k*IW +: IW]] = tot[ix[k*IW +: IW]] + in[k*W +: W];
            end
        end
        for (int b = 0; b < NB; b++)
            model[b] = (le && li == IW'(b)) ? lv : model[b] + tot[b];
        req_vld = v; req_idx = ix; req_inc = in;
        ld_en = le; ld_idx = li; ld_val = lv;
        @(posedge clk);
        @(negedge clk);
        req_vld = '0; ld_en = 1'b0;
        chk(rsp_vld == v, {tag, " R4 valid"}, W'(rsp_vld), W'(v));
        for (int k = 0; k < N; k++) begin
            got[k] = rsp_val[k*W +: W];
            chk(got[k] == exp[k], tag, got[k], exp[k]);
        end
    endtask

    task automatic peek(input int b, input string tag);
        step(N'(1), (N*IW)'(b), '0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) model[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(rsp_vld == '0, "R1 rsp_vld", W'(rsp_vld), 0);
        for (int b = 0; b < NB; b++) peek(b, "R1 base zero");
        // R2: load then read
        for (int b = 0; b < NB; b++) step('0, '0, '0, 1'b1, IW'(b), W'(32'h100 * (b + 1)), "R2 load");
        for (int b = 0; b < NB; b++) peek(b, "R2 loaded value");
        // R3: lone request, then read updated base
        step(4'b0100, {2'd0, 2'd1, 2'd0, 2'd0}, {32'd0, 32'd9, 32'd0, 32'd0}, 1'b0, '0, '0, "R3 lone");
        peek(1, "R3 base advanced");
        // R8: all increment 1 on base 2
        step('1, {2'd2, 2'd2, 2'd2, 2'd2}, {32'd1, 32'd1, 32'd1, 32'd1}, 1'b0, '0, '0, "R8 all ones");
        for (int k = 1; k < N; k++) chk(got[k] == got[0] + W'(k), "R8 consecutive", got[k], got[0] + W'(k));
        peek(2, "R6 base by total");
        // R9: back-to-back on same base
        step(4'b0001, {6'd0, 2'd3}, {96'd0, 32'd5}, 1'b0, '0, '0, "R9 first");
        step(4'b0001, {6'd0, 2'd3}, {96'd0, 32'd6}, 1'b0, '0, '0, "R9 second");
        // R10: wrap
        step('0, '0, '0, 1'b1, 2'd0, 32'hFFFF_FFFE, "R10 load");
        step(4'b0011, {4'd0, 2'd0, 2'd0}, {64'd0, 32'd3, 32'd5}, 1'b0, '0, '0, "R10 wrap");
        peek(0, "R10 wrapped base");
        // R11: load collides with requests
        step(4'b0011, {4'd0, 2'd1, 2'd1}, {64'd0, 32'd4, 32'd4}, 1'b1, 2'd1, 32'h55, "R11 collide");
        peek(1, "R11 load wins");
        // R12: masked lanes with large increments
        step(4'b0000, {2'd0, 2'd1, 2'd2, 2'd3}, {N{32'hDEAD_BEEF}}, 1'b0, '0, '0, "R12 masked");
        for (int b = 0; b < NB; b++) peek(b, "R12 bases unchanged");
        // R5 R6 R7 R12: sweep every index pattern and valid mask
        for (int p = 0; p < (1 << (N*IW)); p++) begin
            for (int m = 0; m < (1 << N); m++) begin
                logic [N*W-1:0] in;
                for (int k = 0; k < N; k++) in[k*W +: W] = W'(p * 13 + k * 7 + m) ^ (W'(k) << 30);
                step(N'(m), (N*IW)'(p), in, (p % 5) == 0 && m == 3, IW'(p), W'(p * 1000), "R5 R6 R7 sweep");
            end
        end
        for (int b = 0; b < NB; b++) peek(b, "R6 final bases");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule